// File: doc/BRIEF.md
# Write-Back Block Cache With Flush Scan

This block puts a fast on-chip word store in front of a large, slow backing memory. The fast store holds exactly one program block. A base register names where that block starts in slow memory. The processor presents word offsets into the block. Every fast location carries two flags: "present" (the word has been brought in) and "modified" (it has been written since it came in). No address tag is stored.

Every access looks at the fast store first. A present word is served without touching slow memory, for reads and writes alike. An absent word is fetched from slow memory at base plus offset and installed. For a write, the fetched word is then overwritten with the write data.

Loading a new base value starts a flush scan. The scan steps through every fast location in ascending order. Each location that is both present and modified is written back to slow memory at the outgoing base plus its offset. Every location has both flags cleared as it is passed. The outgoing base is kept for the whole scan, so write-back addresses stay correct.

Processor requests use valid/ready, and the block holds ready low whenever it is not idle. Requests to slow memory also use valid/ready. Once the block raises the request valid, it keeps it raised, and keeps the address, direction and data unchanged, until ready is seen. A slow-memory read answers with a single-cycle data strobe. The processor response is a single-cycle strobe and has no back-pressure. The base-register port and the busy flag are plain control pins.

Top module: `blk_wb_cache`

## Requirements
- R1: After reset, busy is 0, cpu_req_ready is 1, cpu_rsp_valid is 0 and mem_req_valid is 0. All flags are clear, so the first access to any offset is a miss. While busy is 0, no slow-memory request is pending.
- R2: A read of an absent offset issues exactly one slow read (mem_req_we=0) at base+offset. It installs the returned word and answers with that word. A later read of the same offset answers from the fast store with no slow request. At most one slow read is outstanding at a time.
- R3: A write to a present offset updates only the fast store, with no slow request. It marks the word modified, and the response echoes the write data. A later read returns the new value.
- R4: A write to an absent offset first reads slow memory at base+offset, then stores the write data. It answers with the write data, and the word becomes present and modified.
- R5: A base write accepted while idle raises busy on the next cycle. The scan visits all 2^OFF_W offsets in ascending order, taking at least one cycle each. It issues one slow write (mem_req_we=1) per present-and-modified word, at outgoing base+offset and carrying the fast-store contents. Words that are clean or absent cause no slow traffic.
- R6: When the scan ends, every flag is clear. The next access to any previously present offset misses and fetches from the new base+offset.
- R7: While busy is 1, cpu_req_ready is 0 and base writes are ignored.
- R8: When base_wr_en and a processor request arrive in the same cycle, the base write wins. cpu_req_ready is 0 in that cycle.
- R9: While mem_req_valid is 1 and mem_req_ready is 0, mem_req_valid stays 1 and mem_req_addr, mem_req_we and mem_req_wdata stay stable.
- R10: Slow addresses are base+offset modulo 2^ADDR_W. This holds for fetches and write-backs alike.
- R11: Each accepted processor request yields exactly one cpu_rsp_valid pulse, one cycle wide. It comes on the cycle after acceptance (hit) or the cycle after the slow read data arrives (miss).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Block accepts the request this cycle |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_off | input | OFF_W | Word offset within the active block |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | Single-cycle response strobe |
| cpu_rsp_rdata | output | DATA_W | Read data, or write data echoed for writes |
| base_wr_en | input | 1 | Load a new base value (idle only) |
| base_wr_value | input | ADDR_W | New block start address |
| busy | output | 1 | Miss service or flush scan in progress |
| mem_req_valid | output | 1 | Slow-memory request valid |
| mem_req_ready | input | 1 | Slow memory takes the request |
| mem_req_we | output | 1 | 1 = write-back, 0 = fetch |
| mem_req_addr | output | ADDR_W | Slow-memory word address |
| mem_req_wdata | output | DATA_W | Write-back data |
| mem_rsp_valid | input | 1 | Fetch data strobe |
| mem_rsp_rdata | input | DATA_W | Fetch data |

## Verification
The bench first leaves three words dirty and others clean or absent. It then changes the base under slow-memory back-pressure. A design that skipped the dirty test would flood slow memory with clean writes. One that used the new base for write-back addresses would corrupt the wrong block. One that forgot to clear the flags would serve stale words after the change. A base write poked into the middle of the scan, and another raised together with a processor request, show whether busy really locks both ports. Fetch and write-back addresses past the top of slow memory expose a missing wrap.

// File: rtl/bwc_pkg.sv
`timescale 1ns/1ps
package bwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_FILL_REQ  = 2'd1,
    ST_FILL_WAIT = 2'd2,
    ST_SCAN      = 2'd3
  } bwc_state_e;
endpackage

// File: rtl/bwc_flag_store.sv
`timescale 1ns/1ps
// Present / modified flag pair per fast location, single update port.
module bwc_flag_store #(
  parameter int OFF_W = 10,
  localparam int DEPTH = 1 << OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFF_W-1:0] idx,
  output logic             present,
  output logic             modified,
  input  logic             upd_en,
  input  logic             upd_present,
  input  logic             upd_modified
);
  logic [DEPTH-1:0] present_q;
  logic [DEPTH-1:0] modified_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      present_q  <= '0;
      modified_q <= '0;
    end else if (upd_en) begin
      present_q[idx]  <= upd_present;
      modified_q[idx] <= upd_modified;
    end
  end

  assign present  = present_q[idx];
  assign modified = modified_q[idx];
endmodule

// File: rtl/bwc_word_store.sv
`timescale 1ns/1ps
// Fast word store: asynchronous read, synchronous write, no reset.
module bwc_word_store #(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 10,
  localparam int DEPTH = 1 << OFF_W
) (
  input  logic              clk,
  input  logic [OFF_W-1:0]  idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] words_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) words_q[idx] <= wr_data;
  end

  assign rd_data = words_q[idx];
endmodule

// File: rtl/bwc_ctrl.sv
`timescale 1ns/1ps
// Sequencer: hit service, miss fetch, flush scan.
module bwc_ctrl
  import bwc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 10,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [OFF_W-1:0]  cpu_req_off,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  input  logic              base_wr_en,
  input  logic [ADDR_W-1:0] base_wr_value,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic [OFF_W-1:0]  lk_idx,
  input  logic              lk_present,
  input  logic              lk_modified,
  input  logic [DATA_W-1:0] lk_data,
  output logic              flag_upd,
  output logic              flag_present,
  output logic              flag_modified,
  output logic              word_we,
  output logic [DATA_W-1:0] word_wdata
);
  localparam logic [OFF_W-1:0] LAST_OFF = '1;

  bwc_state_e        state_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] old_base_q;
  logic [OFF_W-1:0]  scan_idx_q;
  logic [OFF_W-1:0]  req_off_q;
  logic              req_we_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              mreq_valid_q;
  logic              mreq_we_q;
  logic [ADDR_W-1:0] mreq_addr_q;
  logic [DATA_W-1:0] mreq_wdata_q;

  logic accept;
  logic dirty_here;
  logic scan_step;

  assign cpu_req_ready = (state_q == ST_IDLE) && !base_wr_en;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign busy          = (state_q != ST_IDLE);
  assign dirty_here    = lk_present && lk_modified;
  assign scan_step     = (state_q == ST_SCAN) &&
                         (mreq_valid_q ? mem_req_ready : !dirty_here);

  always_comb begin
    case (state_q)
      ST_IDLE: lk_idx = cpu_req_off;
      ST_SCAN: lk_idx = scan_idx_q;
      default: lk_idx = req_off_q;
    endcase
  end

  // Flag and word updates, all at lk_idx.
  always_comb begin
    flag_upd      = 1'b0;
    flag_present  = 1'b0;
    flag_modified = 1'b0;
    word_we       = 1'b0;
    word_wdata    = cpu_req_wdata;
    case (state_q)
      ST_IDLE: begin
        if (accept && lk_present && cpu_req_we) begin
          flag_upd      = 1'b1;
          flag_present  = 1'b1;
          flag_modified = 1'b1;
          word_we       = 1'b1;
        end
      end
      ST_FILL_WAIT: begin
        if (mem_rsp_valid) begin
          flag_upd      = 1'b1;
          flag_present  = 1'b1;
          flag_modified = req_we_q;
          word_we       = 1'b1;
          word_wdata    = req_we_q ? req_wdata_q : mem_rsp_rdata;
        end
      end
      ST_SCAN: begin
        flag_upd = scan_step;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      base_q       <= RESET_BASE;
      old_base_q   <= '0;
      scan_idx_q   <= '0;
      req_off_q    <= '0;
      req_we_q     <= 1'b0;
      req_wdata_q  <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_data_q   <= '0;
      mreq_valid_q <= 1'b0;
      mreq_we_q    <= 1'b0;
      mreq_addr_q  <= '0;
      mreq_wdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (base_wr_en) begin
            old_base_q <= base_q;
            base_q     <= base_wr_value;
            scan_idx_q <= '0;
            state_q    <= ST_SCAN;
          end else if (accept) begin
            if (lk_present) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= cpu_req_we ? cpu_req_wdata : lk_data;
            end else begin
              req_off_q    <= cpu_req_off;
              req_we_q     <= cpu_req_we;
              req_wdata_q  <= cpu_req_wdata;
              mreq_valid_q <= 1'b1;
              mreq_we_q    <= 1'b0;
              mreq_addr_q  <= base_q + ADDR_W'(cpu_req_off);
              state_q      <= ST_FILL_REQ;
            end
          end
        end
        ST_FILL_REQ: begin
          if (mem_req_ready) begin
            mreq_valid_q <= 1'b0;
            state_q      <= ST_FILL_WAIT;
          end
        end
        ST_FILL_WAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= req_we_q ? req_wdata_q : mem_rsp_rdata;
            state_q     <= ST_IDLE;
          end
        end
        ST_SCAN: begin
          if (!mreq_valid_q && dirty_here) begin
            mreq_valid_q <= 1'b1;
            mreq_we_q    <= 1'b1;
            mreq_addr_q  <= old_base_q + ADDR_W'(scan_idx_q);
            mreq_wdata_q <= lk_data;
          end
          if (mreq_valid_q && mem_req_ready) mreq_valid_q <= 1'b0;
          if (scan_step) begin
            if (scan_idx_q == LAST_OFF) state_q <= ST_IDLE;
            else scan_idx_q <= scan_idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_data_q;
  assign mem_req_valid = mreq_valid_q;
  assign mem_req_we    = mreq_we_q;
  assign mem_req_addr  = mreq_addr_q;
  assign mem_req_wdata = mreq_wdata_q;
endmodule

// File: rtl/blk_wb_cache.sv
`timescale 1ns/1ps
module blk_wb_cache #(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 10,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [OFF_W-1:0]  cpu_req_off,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  input  logic              base_wr_en,
  input  logic [ADDR_W-1:0] base_wr_value,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  logic [OFF_W-1:0]  lk_idx;
  logic              lk_present;
  logic              lk_modified;
  logic [DATA_W-1:0] lk_data;
  logic              flag_upd;
  logic              flag_present;
  logic              flag_modified;
  logic              word_we;
  logic [DATA_W-1:0] word_wdata;

  bwc_ctrl #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .RESET_BASE(RESET_BASE)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_off(cpu_req_off),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .base_wr_en(base_wr_en), .base_wr_value(base_wr_value), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .lk_idx(lk_idx), .lk_present(lk_present), .lk_modified(lk_modified),
    .lk_data(lk_data),
    .flag_upd(flag_upd), .flag_present(flag_present),
    .flag_modified(flag_modified),
    .word_we(word_we), .word_wdata(word_wdata)
  );

  bwc_flag_store #(.OFF_W(OFF_W)) u_flags (
    .clk(clk), .rst(rst), .idx(lk_idx),
    .present(lk_present), .modified(lk_modified),
    .upd_en(flag_upd), .upd_present(flag_present),
    .upd_modified(flag_modified)
  );

  bwc_word_store #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_words (
    .clk(clk), .idx(lk_idx), .rd_data(lk_data),
    .wr_en(word_we), .wr_data(word_wdata)
  );
endmodule

// File: rtl/bwc_checker.sv
`timescale 1ns/1ps
module bwc_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              base_wr_en,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid
);
  logic rd_open_q;
  logic rd_fire;

  assign rd_fire = mem_req_valid && mem_req_ready && !mem_req_we;

  always_ff @(posedge clk) begin
    if (rst) rd_open_q <= 1'b0;
    else if (rd_fire) rd_open_q <= 1'b1;
    else if (mem_rsp_valid) rd_open_q <= 1'b0;
  end

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid);

  assert_single_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    rd_fire |-> !rd_open_q);

  assert_scan_starts_R5: assert property (@(posedge clk) disable iff (rst)
    (base_wr_en && !busy) |=> busy);

  assert_busy_locks_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cpu_req_ready);

  assert_base_wins_R8: assert property (@(posedge clk) disable iff (rst)
    base_wr_en |-> !cpu_req_ready);

  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) &&
       $stable(mem_req_wdata)));

  assert_rsp_has_cause_R11: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |-> ($past(cpu_req_valid && cpu_req_ready) || $past(mem_rsp_valid)));
endmodule

bind blk_wb_cache bwc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bwc_checker (
  .clk(clk), .rst(rst),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid),
  .base_wr_en(base_wr_en), .busy(busy),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/test_blk_wb_cache.sv
`timescale 1ns/1ps
module test_blk_wb_cache;
  localparam int DW = 16;
  localparam int OW = 10;
  localparam int AW = 16;
  localparam int DEPTH = 1 << OW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req_valid = 1'b0;
  logic          cpu_req_ready;
  logic          cpu_req_we = 1'b0;
  logic [OW-1:0] cpu_req_off = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          base_wr_en = 1'b0;
  logic [AW-1:0] base_wr_value = '0;
  logic          busy;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic          mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_rdata = '0;

  always #2.5 clk = ~clk;

  blk_wb_cache #(.DATA_W(DW), .OFF_W(OW), .ADDR_W(AW)) i_blk_wb_cache (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_off(cpu_req_off),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .base_wr_en(base_wr_en), .base_wr_value(base_wr_value), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [DW-1:0] slowval(input logic [AW-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  // Slow memory model: decides ready at each falling edge, answers reads two edges later.
  bit            stall = 0;
  int            tick = 0;
  int            rd_count = 0;
  logic [AW-1:0] last_rd_addr = '0;
  int            rcnt = 0;
  logic [AW-1:0] raddr = '0;
  int            wcnt = 0;
  logic [AW-1:0] wlog_addr [64];
  logic [DW-1:0] wlog_data [64];

  initial begin
    forever begin
      @(negedge clk);
      tick++;
      mem_rsp_valid = 1'b0;
      if (rcnt > 0) begin
        rcnt--;
        if (rcnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = slowval(raddr);
        end
      end
      mem_req_ready = !stall || (tick % 3 == 0);
      if (!rst && mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          if (wcnt < 64) begin
            wlog_addr[wcnt] = mem_req_addr;
            wlog_data[wcnt] = mem_req_wdata;
          end
          wcnt++;
        end else begin
          rd_count++;
          last_rd_addr = mem_req_addr;
          raddr = mem_req_addr;
          rcnt = 2;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  task automatic access(input bit we, input int off, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_we    = we;
    cpu_req_off   = OW'(off);
    cpu_req_wdata = wd;
    #1;
    while (!cpu_req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (!cpu_rsp_valid) @(negedge clk);
    rd = cpu_rsp_rdata;
    @(negedge clk);
    chk("R11 single-cycle response", {31'd0, cpu_rsp_valid}, 32'd0);
  endtask

  task automatic flush(input logic [AW-1:0] nb, input bit stall_on, input bit poke);
    int cyc;
    wcnt  = 0;
    stall = stall_on;
    @(negedge clk);
    base_wr_en    = 1'b1;
    base_wr_value = nb;
    @(negedge clk);
    base_wr_en = 1'b0;
    chk("R5 busy after base write", {31'd0, busy}, 32'd1);
    chk("R7 ready low while busy", {31'd0, cpu_req_ready}, 32'd0);
    cyc = 1;
    if (poke) begin
      base_wr_en    = 1'b1;
      base_wr_value = 16'h1234;
      @(negedge clk);
      base_wr_en = 1'b0;
      cyc++;
    end
    while (busy) begin
      @(negedge clk);
      cyc++;
    end
    stall = 0;
    chk("R5 scan visits every offset", {31'd0, cyc >= DEPTH}, 32'd1);
  endtask

  typedef struct packed {
    bit          we;
    bit [OW-1:0] off;
    bit [DW-1:0] val;
    bit          from_slow;
    bit          slow_rd;
    bit [3:0]    req;
  } vec_t;

  // base is 0 while the table runs
  localparam vec_t VEC_TBL [9] = '{
    '{1'b0, 10'd5,    16'h0000, 1'b1, 1'b1, 4'd2},  // R2 read miss
    '{1'b0, 10'd5,    16'h0000, 1'b1, 1'b0, 4'd2},  // R2 read hit
    '{1'b1, 10'd5,    16'h1111, 1'b0, 1'b0, 4'd3},  // R3 write hit
    '{1'b0, 10'd5,    16'h1111, 1'b0, 1'b0, 4'd3},  // R3 read back
    '{1'b1, 10'd9,    16'h2222, 1'b0, 1'b1, 4'd4},  // R4 write miss
    '{1'b0, 10'd9,    16'h2222, 1'b0, 1'b0, 4'd4},  // R4 read back
    '{1'b0, 10'd1023, 16'h0000, 1'b1, 1'b1, 4'd2},  // R2 top offset
    '{1'b1, 10'd0,    16'h3333, 1'b0, 1'b1, 4'd4},  // R4 offset zero
    '{1'b0, 10'd12,   16'h0000, 1'b1, 1'b1, 4'd2}   // R2 clean present
  };

  initial begin
    logic [DW-1:0] rd;
    int rc0;
    string tag;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 cpu_req_ready", {31'd0, cpu_req_ready}, 32'd1);
    chk("R1 cpu_rsp_valid", {31'd0, cpu_rsp_valid}, 32'd0);
    chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);

    foreach (VEC_TBL[i]) begin
      vec_t v;
      logic [DW-1:0] exp;
      v = VEC_TBL[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      rc0 = rd_count;
      access(v.we, int'(v.off), v.val, rd);
      exp = v.from_slow ? slowval(AW'(v.off)) : v.val;
      chk({tag, " data"}, {16'd0, rd}, {16'd0, exp});
      chk({tag, " slow reads"}, rd_count - rc0, v.slow_rd ? 1 : 0);
      if (v.slow_rd) chk({tag, " fetch addr"}, {16'd0, last_rd_addr}, {16'd0, AW'(v.off)});
    end

    // R5 flush under back-pressure (R9), with an ignored base write mid-scan (R7)
    flush(16'hFFF0, 1'b1, 1'b1);
    chk("R5 write-back count", wcnt, 3);
    chk("R5 wb0 addr", {16'd0, wlog_addr[0]}, 32'h0000);
    chk("R5 wb0 data", {16'd0, wlog_data[0]}, 32'h3333);
    chk("R5 wb1 addr", {16'd0, wlog_addr[1]}, 32'h0005);
    chk("R5 wb1 data", {16'd0, wlog_data[1]}, 32'h1111);
    chk("R5 wb2 addr", {16'd0, wlog_addr[2]}, 32'h0009);
    chk("R5 wb2 data", {16'd0, wlog_data[2]}, 32'h2222);

    // R6 flags cleared; R7 mid-scan base write had no effect
    rc0 = rd_count;
    access(1'b0, 5, 16'h0, rd);
    chk("R6 refetch after scan", rd_count - rc0, 1);
    chk("R7 base kept at first value", {16'd0, last_rd_addr}, 32'hFFF5);
    chk("R6 data from new block", {16'd0, rd}, {16'd0, slowval(16'hFFF5)});

    // R10 fetch wraps; R9 fetch under stall
    stall = 1;
    rc0 = rd_count;
    access(1'b0, 20, 16'h0, rd);
    stall = 0;
    chk("R10 wrapped fetch addr", {16'd0, last_rd_addr}, 32'h0004);
    chk("R9 data under stall", {16'd0, rd}, {16'd0, slowval(16'h0004)});
    rc0 = rd_count;
    access(1'b1, 20, 16'h4444, rd);
    chk("R3 write hit no slow read", rd_count - rc0, 0);
    chk("R3 write echo", {16'd0, rd}, 32'h4444);
    access(1'b0, 1023, 16'h0, rd);
    chk("R6 top offset refetched", {16'd0, last_rd_addr}, 32'h03EF);

    // R8 base write and processor request together
    wcnt = 0;
    rc0  = rd_count;
    @(negedge clk);
    base_wr_en    = 1'b1;
    base_wr_value = 16'h0100;
    cpu_req_valid = 1'b1;
    cpu_req_we    = 1'b0;
    cpu_req_off   = OW'(20);
    #1;
    chk("R8 ready low with base write", {31'd0, cpu_req_ready}, 32'd0);
    @(negedge clk);
    base_wr_en    = 1'b0;
    cpu_req_valid = 1'b0;
    chk("R8 base write taken", {31'd0, busy}, 32'd1);
    while (busy) @(negedge clk);
    chk("R8 request not taken", rd_count - rc0, 0);
    chk("R5 single dirty write-back", wcnt, 1);
    chk("R10 wrapped write-back addr", {16'd0, wlog_addr[0]}, 32'h0004);
    chk("R5 write-back data", {16'd0, wlog_data[0]}, 32'h4444);
    access(1'b0, 20, 16'h0, rd);
    chk("R6 fetch from new base", {16'd0, last_rd_addr}, 32'h0114);
    chk("R6 new base data", {16'd0, rd}, {16'd0, slowval(16'h0114)});

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule